// File: doc/BRIEF.md
# One-time-programmable protection register with lockout

This block holds a 128-bit one-time-programmable identification area and the lock word that guards it. It is the kind found beside a parallel NOR flash array. The area has two 64-bit halves. The factory half holds a fixed device number, set by a parameter and read-only from reset. The user half can be programmed until the user locks it.

Accesses arrive on a plain request port. The address is byte-style: bit 0 is ignored, bits 8 to 1 give the word, and the upper bits must be zero.

Reads return data one cycle after the strobe. A program strobe starts an operation that stays busy for a fixed number of cycles. It then pulses done and commits the result with flash semantics: the new data is ANDed into the stored word, so bits can only clear. Attempts on a locked half change nothing and raise sticky error flags in the status byte.

Top module: `otp_protreg`

## Requirements
- R1: After reset, `status` is 0x80, `busy` and `done` are 0, the lock word reads 0xFFFE, the user words read 0xFFFF and the factory words read the `FACTORY_ID` parameter.
- R2: The word index is `addr[8:1]` and `addr[0]` is ignored. Index 0x80 is the lock word. Indices 0x81 to 0x84 are factory words 0 to 3, and word k is `FACTORY_ID[16k+15:16k]`. Indices 0x85 to 0x88 are user words 0 to 3. `rdata` holds the word addressed at the last `rd_en` edge, valid from the cycle after that edge.
- R3: An access that has any address bit above bit 8 set, or an index outside 0x80 to 0x88, is ignored. A read returns 0xFFFF. A program does not raise `busy` and changes no stored word.
- R4: A program accepted at a clock edge holds `busy` high for `PGM_CYCLES` cycles. Then `done` is high for exactly one cycle. At that point the target word becomes its old value AND `wdata`.
- R5: Bit 0 of the lock word is 0 from reset, so a program to a factory word leaves the data unchanged and sets status bits 4 and 1.
- R6: Programming 0xFFFD into the lock word clears its bit 1. After that, a program to a user word leaves the data unchanged and sets status bits 4 and 1.
- R7: A lock bit that is 0 stays 0. The lock word is itself programmed by AND, so writing 0xFFFF to it keeps both lock bits at 0.
- R8: Status bits 4 and 1 stay set through later successful programs until a one-cycle `clr_status` pulse clears them. All other status bits are 0 except bit 7.
- R9: Status bit 7 is 1 when idle and 0 while busy. A program strobe while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Byte-style request address |
| wdata | input | 16 | Program data |
| rd_en | input | 1 | Read strobe |
| pgm_en | input | 1 | Program strobe |
| clr_status | input | 1 | Clears the error status bits |
| rdata | output | 16 | Read data |
| busy | output | 1 | Program operation in progress |
| done | output | 1 | One-cycle pulse at program completion |
| status | output | 8 | Bit 7 ready, bit 4 program error, bit 1 lock error |

## Verification
Directed sequences walk every index and both values of the ignored address bit. They also touch the neighbours just outside the window and a set high bit, which separates a correct decoder from one that aliases or drops address bits. Successive programs to one word use overlapping patterns, so a read-back shows AND behaviour rather than overwrite. Programs to the factory half, to a user word after lockout, and to the lock word with all ones separate a frozen half from one that only flags an error or lets a lock bit come back. Random runs of reads, programs, clears and strobes issued mid-operation are then checked against a bench model, before and after the user lock.

// File: rtl/otp_protreg.sv
module otp_protreg #(
  parameter int          ADDR_W     = 23,
  parameter int          PGM_CYCLES = 8,
  parameter logic [63:0] FACTORY_ID = 64'h0123_4567_89AB_CDEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  input  logic              rd_en,
  input  logic              pgm_en,
  input  logic              clr_status,
  output logic [15:0]       rdata,
  output logic              busy,
  output logic              done,
  output logic [7:0]        status
);
  localparam int CNT_W = $clog2(PGM_CYCLES + 1);

  logic [15:0]      lock_q;
  logic [63:0]      user_q;
  logic [15:0]      rdata_q, data_q;
  logic [3:0]       tgt_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q, err_q;

  wire       hi_zero = (addr[ADDR_W-1:9] == '0);
  wire [3:0] idx     = addr[4:1];
  wire       hit     = hi_zero && (addr[8:5] == 4'b1000) && (idx <= 4'd8);
  wire       start   = pgm_en && hit && !busy_q;
  wire       finish  = busy_q && (cnt_q == '0);

  function automatic logic [15:0] word_at(input logic [3:0] i, input logic [15:0] lk,
                                          input logic [63:0] us);
    case (i)
      4'd0:    word_at = lk;
      4'd1:    word_at = FACTORY_ID[15:0];
      4'd2:    word_at = FACTORY_ID[31:16];
      4'd3:    word_at = FACTORY_ID[47:32];
      4'd4:    word_at = FACTORY_ID[63:48];
      4'd5:    word_at = us[15:0];
      4'd6:    word_at = us[31:16];
      4'd7:    word_at = us[47:32];
      4'd8:    word_at = us[63:48];
      default: word_at = 16'hFFFF;
    endcase
  endfunction

  wire tgt_user    = (tgt_q >= 4'd5);
  wire tgt_factory = (tgt_q >= 4'd1) && (tgt_q <= 4'd4);
  wire blocked     = (tgt_factory && lock_q[0]) ? 1'b0 :
                     tgt_factory ? 1'b1 : (tgt_user && !lock_q[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q  <= 16'hFFFE;
      user_q  <= '1;
      rdata_q <= 16'hFFFF;
      data_q  <= '1;
      tgt_q   <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (rd_en)
        rdata_q <= hit ? word_at(idx, lock_q, user_q) : 16'hFFFF;
      if (clr_status)
        err_q <= 1'b0;
      if (start) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(PGM_CYCLES - 1);
        tgt_q  <= idx;
        data_q <= wdata;
      end else if (finish) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        if (blocked)
          err_q <= 1'b1;
        else if (tgt_q == 4'd0)
          lock_q <= lock_q & data_q;
        else
          for (int i = 0; i < 4; i++)
            if (tgt_q == 4'(i + 5))
              user_q[16*i +: 16] <= user_q[16*i +: 16] & data_q;
      end else if (busy_q) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign rdata  = rdata_q;
  assign busy   = busy_q;
  assign done   = done_q;
  assign status = {~busy_q, 2'b00, err_q, 2'b00, err_q, 1'b0};

  AST_LOCK_ONE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q[1:0] & ~$past(lock_q[1:0])) == 2'b00);  // R7
  AST_USER_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_q[1] |=> $stable(user_q));  // R6
  AST_AND_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (user_q & ~$past(user_q)) == 64'd0);  // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (status[4] && !clr_status) |=> status[4]);  // R8
  AST_BADADDR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && pgm_en && !hit) |=> !busy);  // R3
  AST_READY_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    status[7] == !busy);  // R9
endmodule

// File: tb/tb_otp_protreg.sv
`timescale 1ns/1ps
module tb_otp_protreg;
  localparam int          AW = 23;
  localparam int          P  = 8;
  localparam logic [63:0] FID = 64'h0123_4567_89AB_CDEF;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0]   wdata = '0;
  logic          rd_en = 1'b0, pgm_en = 1'b0, clr_status = 1'b0;
  logic [15:0]   rdata;
  logic          busy, done;
  logic [7:0]    status;

  otp_protreg #(.ADDR_W(AW), .PGM_CYCLES(P), .FACTORY_ID(FID)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .rd_en(rd_en),
    .pgm_en(pgm_en), .clr_status(clr_status), .rdata(rdata), .busy(busy),
    .done(done), .status(status));

  always #2.5 clk = ~clk;

  int total = 0, bad = 0;
  logic [15:0] m_lock = 16'hFFFE;
  logic [15:0] m_user [4] = '{default: 16'hFFFF};
  logic        m_err = 1'b0;

  function automatic logic [AW-1:0] mk(input logic [7:0] w, input logic a0);
    return {{(AW-9){1'b0}}, w, a0};
  endfunction

  function automatic logic is_hit(input logic [AW-1:0] a);
    return (a[AW-1:9] == '0) && (a[8:1] >= 8'h80) && (a[8:1] <= 8'h88);
  endfunction

  function automatic logic [15:0] exp_word(input logic [AW-1:0] a);
    int i;
    if (!is_hit(a)) return 16'hFFFF;
    i = int'(a[8:1]) - 8'h80;
    if (i == 0) return m_lock;
    if (i <= 4) return FID[16*(i-1) +: 16];
    return m_user[i-5];
  endfunction

  function automatic logic [7:0] exp_status(input logic bz);
    return {~bz, 2'b00, m_err, 2'b00, m_err, 1'b0};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_read(input logic [AW-1:0] a, input string tag);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    chk(tag, {16'd0, rdata}, {16'd0, exp_word(a)});
  endtask

  task automatic model_pgm(input logic [AW-1:0] a, input logic [15:0] d);
    int i;
    i = int'(a[8:1]) - 8'h80;
    if (i == 0) m_lock = m_lock & d;
    else if (i <= 4) begin if (m_lock[0]) ; else m_err = 1'b1; end
    else if (m_lock[1]) m_user[i-5] = m_user[i-5] & d;
    else m_err = 1'b1;
  endtask

  task automatic do_pgm(input logic [AW-1:0] a, input logic [15:0] d, input string tag,
                        input logic strobe_mid);
    int n;
    @(negedge clk); addr = a; wdata = d; pgm_en = 1'b1;
    @(negedge clk); pgm_en = 1'b0;
    if (!is_hit(a)) begin
      chk({tag, " R3 no busy"}, {31'd0, busy}, 32'd0);
      return;
    end
    chk({tag, " R9 busy status"}, {24'd0, status}, {24'd0, exp_status(1'b1)});
    n = 1;
    if (strobe_mid) begin
      addr = mk(8'h87, 1'b0); wdata = 16'h0000; pgm_en = 1'b1;
      @(negedge clk); pgm_en = 1'b0; n++;
    end
    while (!done && n < 100) begin @(negedge clk); n++; end
    chk({tag, " R4 done timing"}, n, P + 1);
    model_pgm(a, d);
    @(negedge clk);
    chk({tag, " R4 done one cycle"}, {31'd0, done}, 32'd0);
    chk({tag, " R8 status"}, {24'd0, status}, {24'd0, exp_status(1'b0)});
  endtask

  task automatic do_clr();
    @(negedge clk); clr_status = 1'b1;
    @(negedge clk); clr_status = 1'b0;
    m_err = 1'b0;
    chk("R8 clear", {24'd0, status}, {24'd0, exp_status(1'b0)});
  endtask

  task automatic rnd_phase(input int count);
    for (int k = 0; k < count; k++) begin
      logic [AW-1:0] a;
      int r;
      r = $urandom_range(0, 9);
      a = mk(8'h7E + 8'($urandom_range(0, 12)), 1'($urandom_range(0, 1)));
      if (r == 0) a[AW-1 - $urandom_range(0, AW-10)] = 1'b1;
      r = $urandom_range(0, 9);
      if (r < 5) do_read(a, "R2 random read");
      else if (r < 9) begin
        if (a[8:1] == 8'h80 && $urandom_range(0, 3) != 0) a[1] = 1'b1;
        do_pgm(a, 16'($urandom), "R4 random pgm", 1'($urandom_range(0, 4) == 0));
      end else do_clr();
    end
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 status", {24'd0, status}, 32'h80);
    chk("R1 busy", {31'd0, busy}, 0);
    chk("R1 done", {31'd0, done}, 0);
    for (int w = 8'h80; w <= 8'h88; w++) do_read(mk(8'(w), 1'b0), "R1 R2 reset read");
    do_read(mk(8'h81, 1'b1), "R2 A0 ignored");
    do_read(mk(8'h86, 1'b1), "R2 A0 ignored user");
    do_read(mk(8'h89, 1'b0), "R3 above window");
    do_read(mk(8'h7F, 1'b0), "R3 below window");
    do_read(mk(8'h81, 1'b0) | (AW'(1) << 9), "R3 high bit read");
    do_pgm(mk(8'h85, 1'b0) | (AW'(1) << 9), 16'h0000, "R3 high bit pgm", 1'b0);
    do_pgm(mk(8'h89, 1'b0), 16'h0000, "R3 out pgm", 1'b0);
    do_read(mk(8'h85, 1'b0), "R3 untouched");
    do_pgm(mk(8'h85, 1'b0), 16'h00FF, "R4 first", 1'b0);
    do_read(mk(8'h85, 1'b0), "R4 readback");
    do_pgm(mk(8'h85, 1'b1), 16'hF0F0, "R4 second", 1'b0);
    do_read(mk(8'h85, 1'b0), "R4 AND result");
    chk("R4 model", {16'd0, m_user[0]}, 32'h00F0);
    do_pgm(mk(8'h82, 1'b0), 16'h0000, "R5 factory pgm", 1'b0);
    chk("R5 err bits", {24'd0, status}, 32'h92);
    do_read(mk(8'h82, 1'b0), "R5 factory unchanged");
    do_pgm(mk(8'h88, 1'b0), 16'h7FFF, "R8 ok pgm keeps err", 1'b0);
    chk("R8 sticky", {24'd0, status}, 32'h92);
    do_clr();
    do_pgm(mk(8'h86, 1'b0), 16'hAAAA, "R9 mid strobe", 1'b1);
    do_read(mk(8'h87, 1'b0), "R9 ignored strobe");
    do_read(mk(8'h86, 1'b0), "R9 first op");
    rnd_phase(300);
    do_pgm(mk(8'h80, 1'b0), 16'hFFFD, "R6 lock user", 1'b0);
    do_read(mk(8'h80, 1'b0), "R6 lock word");
    chk("R6 lock model", {16'd0, m_lock}, {16'd0, m_lock & 16'hFFFC});
    do_clr();
    do_pgm(mk(8'h86, 1'b0), 16'h0000, "R6 locked pgm", 1'b0);
    chk("R6 err bits", {24'd0, status}, 32'h92);
    do_read(mk(8'h86, 1'b0), "R6 user unchanged");
    do_pgm(mk(8'h80, 1'b0), 16'hFFFF, "R7 relock attempt", 1'b0);
    do_read(mk(8'h80, 1'b0), "R7 lock stays");
    rnd_phase(200);
    for (int w = 8'h80; w <= 8'h88; w++) do_read(mk(8'(w), 1'b0), "R2 final read");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule